// File: doc/BRIEF.md
# Two-Stage Extended Address Bus Bridge

This block is a peripheral bridge on a processor system bus whose data path is N bits wide. It drives a separate external bus with an N-bit data path and a 2N-bit address, so the external space holds 2^(2N) locations. The external address does not come from the system address lines. Software builds it by writing two data words to two dedicated conversion ports. The bridge takes up three system-bus ports in all: a low-half address port, a high-half address port, and a data port.

Software normally loads both halves of the address once. After that it reads or writes the data port as many times as needed. Each data-port access runs one external cycle at the held address. A data-port write pulses the external write strobe for one cycle, with the address and data stable. A data-port read pulses the external read strobe for one cycle. The bridge captures the external data at the end of that cycle and returns it to the host one cycle later, together with an acknowledge. Reading either address port gives back the current contents of that address half.

The host issues accesses as single-cycle requests (chip select together with a write or read enable). It must leave at least one idle cycle after a data-port read before starting the next access.

Top module: `xbus_bridge`

## Requirements
- R1: Port decode on the 2-bit `sysAddr`: 0 is the low address half, 1 is the high address half, 2 is the data port. An access to port 3, or any cycle with `sysCs` low, is ignored. It causes no external strobe and no acknowledge, and it leaves `extAddr` unchanged.
- R2: A write to port 0 loads `extAddr[N-1:0]` and a write to port 1 loads `extAddr[2N-1:N]` from `sysWdata`. Both are visible in the cycle after the accepting clock edge, and `sysAck` pulses high in that same cycle.
- R3: Neither address half changes except through a write to its own port. Data-port accesses leave `extAddr` unchanged.
- R4: A data-port write raises `extWrStb` for exactly one cycle, the cycle after the accepting edge. During that cycle `extWdata` equals the written word, `extAddr` equals the held address and `sysAck` is high.
- R5: A data-port read raises `extRdStb` for exactly one cycle, the cycle after the accepting edge. `extRdata` is sampled at the end of that cycle. In the following cycle `sysRdata` carries the sampled word and `sysAck` is high. `sysAck` stays low while the strobe is high.
- R6: A read of port 0 or port 1 returns the matching address half on `sysRdata`, with `sysAck` high, in the cycle after the accepting edge. No external strobe is raised.
- R7: While `rstN` is low, both address halves, `extWdata` and `sysRdata` clear to zero, and `extWrStb`, `extRdStb` and `sysAck` stay low.
- R8: When `sysWe` and `sysRe` are both high in one access, the access is treated as a write.
- R9: `extWrStb` and `extRdStb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| sysCs | input | 1 | Chip select for the bridge |
| sysAddr | input | 2 | Port select (0 low half, 1 high half, 2 data) |
| sysWe | input | 1 | Write request, one cycle per access |
| sysRe | input | 1 | Read request, one cycle per access |
| sysWdata | input | DATA_W | Write data from the host |
| sysRdata | output | DATA_W | Read data returned to the host |
| sysAck | output | 1 | Access acknowledge pulse |
| extAddr | output | 2*DATA_W | External bus address |
| extWdata | output | DATA_W | External bus write data |
| extRdata | input | DATA_W | External bus read data |
| extWrStb | output | 1 | External write strobe |
| extRdStb | output | 1 | External read strobe |

## Verification
The bound checker tests these rules on every cycle. A data-port write gives exactly one write-strobe cycle. A data-port read gives one read-strobe cycle, followed by an acknowledge. The two strobes never overlap. The address holds whenever no conversion port is written. Other behaviour shows up only in the bench's scenarios, where a reference model tracks the two address halves. That covers the bit placement of each address half, the values returned from the address ports, and the external word that comes back on a read. It also covers the cases where accesses to port 3, accesses with chip select low, and combined write-and-read requests leave that model's state intact.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int PORT_W = 2;

  typedef enum logic [PORT_W-1:0] {
    PORT_ADDR_LO = 2'd0,
    PORT_ADDR_HI = 2'd1,
    PORT_DATA    = 2'd2,
    PORT_NONE    = 2'd3
  } portSel_e;

  typedef struct packed {
    logic ldLo;     // load low address half this edge
    logic ldHi;     // load high address half this edge
    logic ldWdata;  // latch outbound data this edge
    logic retLo;    // return low half on read bus
    logic retHi;    // return high half on read bus
    logic capture;  // sample external read data this edge
  } ctrlStrobes_t;
endpackage

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysCs,
  input  logic [PORT_W-1:0] sysAddr,
  input  logic              sysWe,
  input  logic              sysRe,
  output ctrlStrobes_t      strobes,
  output logic              extWrStb,
  output logic              extRdStb,
  output logic              sysAck
);
  portSel_e port;
  logic     isWrite;
  logic     isRead;
  logic     hitLo;
  logic     hitHi;
  logic     hitData;
  logic     ackNext;

  always_comb begin
    port    = portSel_e'(sysAddr);
    isWrite = sysCs && sysWe;              // write wins over read
    isRead  = sysCs && sysRe && !sysWe;
    hitLo   = (port == PORT_ADDR_LO);
    hitHi   = (port == PORT_ADDR_HI);
    hitData = (port == PORT_DATA);
  end

  always_comb begin
    strobes.ldLo    = isWrite && hitLo;
    strobes.ldHi    = isWrite && hitHi;
    strobes.ldWdata = isWrite && hitData;
    strobes.retLo   = isRead && hitLo;
    strobes.retHi   = isRead && hitHi;
    strobes.capture = extRdStb;
  end

  always_comb begin
    ackNext = (isWrite && (hitLo || hitHi || hitData))
            || (isRead && (hitLo || hitHi))
            || extRdStb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extWrStb <= 1'b0;
      extRdStb <= 1'b0;
      sysAck   <= 1'b0;
    end else begin
      extWrStb <= isWrite && hitData;
      extRdStb <= isRead && hitData;
      sysAck   <= ackNext;
    end
  end
endmodule

// File: rtl/xbus_dpath.sv
module xbus_dpath
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int EXT_AW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] sysWdata,
  input  logic [DATA_W-1:0] extRdata,
  output logic [DATA_W-1:0] sysRdata,
  output logic [EXT_AW-1:0] extAddr,
  output logic [DATA_W-1:0] extWdata
);
  localparam int HALVES = 2;

  logic [DATA_W-1:0] addrHalf [HALVES];
  logic [HALVES-1:0] loadHalf;

  assign loadHalf = {strobes.ldHi, strobes.ldLo};

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            addrHalf[h] <= '0;
      else if (loadHalf[h]) addrHalf[h] <= sysWdata;
    end
    assign extAddr[h*DATA_W +: DATA_W] = addrHalf[h];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                extWdata <= '0;
    else if (strobes.ldWdata) extWdata <= sysWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sysRdata <= '0;
    else if (strobes.capture) sysRdata <= extRdata;
    else if (strobes.retLo)   sysRdata <= addrHalf[0];
    else if (strobes.retHi)   sysRdata <= addrHalf[1];
  end
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sysCs,
  input  logic [1:0]            sysAddr,
  input  logic                  sysWe,
  input  logic                  sysRe,
  input  logic [DATA_W-1:0]     sysWdata,
  output logic [DATA_W-1:0]     sysRdata,
  output logic                  sysAck,
  output logic [2*DATA_W-1:0]   extAddr,
  output logic [DATA_W-1:0]     extWdata,
  input  logic [DATA_W-1:0]     extRdata,
  output logic                  extWrStb,
  output logic                  extRdStb
);
  ctrlStrobes_t strobes;

  xbus_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sysCs    (sysCs),
    .sysAddr  (sysAddr),
    .sysWe    (sysWe),
    .sysRe    (sysRe),
    .strobes  (strobes),
    .extWrStb (extWrStb),
    .extRdStb (extRdStb),
    .sysAck   (sysAck)
  );

  xbus_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .sysWdata (sysWdata),
    .extRdata (extRdata),
    .sysRdata (sysRdata),
    .extAddr  (extAddr),
    .extWdata (extWdata)
  );
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                sysCs,
  input logic [1:0]          sysAddr,
  input logic                sysWe,
  input logic                sysRe,
  input logic                sysAck,
  input logic [2*DATA_W-1:0] extAddr,
  input logic                extWrStb,
  input logic                extRdStb
);
  logic dataWrReq;
  logic dataRdReq;
  logic convWrReq;

  assign dataWrReq = sysCs && sysWe && (sysAddr == 2'd2);
  assign dataRdReq = sysCs && sysRe && !sysWe && (sysAddr == 2'd2);
  assign convWrReq = sysCs && sysWe && (sysAddr[1] == 1'b0);

  assert_wr_strobe_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataWrReq |=> extWrStb);
  assert_wr_strobe_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !dataWrReq |=> !extWrStb);
  assert_rd_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    dataRdReq |=> extRdStb);
  assert_rd_ack_R5: assert property (@(posedge clk) disable iff (!rstN)
    extRdStb |=> sysAck);
  assert_rd_ack_late_R5: assert property (@(posedge clk) disable iff (!rstN)
    extRdStb |-> !sysAck);
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !convWrReq |=> $stable(extAddr));
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(extWrStb && extRdStb));
endmodule

bind xbus_bridge xbus_bridge_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sysCs    (sysCs),
  .sysAddr  (sysAddr),
  .sysWe    (sysWe),
  .sysRe    (sysRe),
  .sysAck   (sysAck),
  .extAddr  (extAddr),
  .extWrStb (extWrStb),
  .extRdStb (extRdStb)
);

// File: tb/tb_xbus_bridge.sv
module tb_xbus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sysCs = 1'b0;
  logic [1:0]    sysAddr = '0;
  logic          sysWe = 1'b0;
  logic          sysRe = 1'b0;
  logic [DW-1:0] sysWdata = '0;
  logic [DW-1:0] sysRdata;
  logic          sysAck;
  logic [2*DW-1:0] extAddr;
  logic [DW-1:0] extWdata;
  wire  [DW-1:0] extRdata;
  logic          extWrStb;
  logic          extRdStb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] mLo = '0;
  logic [DW-1:0] mHi = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] devWord(input logic [2*DW-1:0] a);
    return a[DW-1:0] ^ {a[DW-2:0], a[DW-1]} ^ a[2*DW-1:DW] ^ 8'h5A;
  endfunction

  assign extRdata = devWord(extAddr);

  xbus_bridge #(.DATA_W(DW)) dut (
    .clk(clk), .rstN(rstN), .sysCs(sysCs), .sysAddr(sysAddr),
    .sysWe(sysWe), .sysRe(sysRe), .sysWdata(sysWdata),
    .sysRdata(sysRdata), .sysAck(sysAck), .extAddr(extAddr),
    .extWdata(extWdata), .extRdata(extRdata),
    .extWrStb(extWrStb), .extRdStb(extRdStb)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One access, observed in the two cycles after the accepting edge.
  task automatic txn(input bit cs, input logic [1:0] port, input bit we,
                     input bit re, input logic [DW-1:0] wd);
    bit acc, isW, isR;
    logic [2*DW-1:0] held;
    held = {mHi, mLo};
    acc = cs && (port != 2'd3) && (we || re);
    isW = acc && we;
    isR = acc && re && !we;
    sysCs = cs; sysAddr = port; sysWe = we; sysRe = re; sysWdata = wd;
    @(negedge clk);
    sysCs = 1'b0; sysWe = 1'b0; sysRe = 1'b0;
    if (isW && port == 2'd0) mLo = wd;
    if (isW && port == 2'd1) mHi = wd;
    // first cycle after the edge
    check(extWrStb == (isW && port == 2'd2), "R4 wr strobe", extWrStb, isW && port == 2'd2);
    check(extRdStb == (isR && port == 2'd2), "R5 rd strobe", extRdStb, isR && port == 2'd2);
    check(sysAck == (isW || (isR && port != 2'd2)), "R2 R6 ack", sysAck,
          isW || (isR && port != 2'd2));
    check(extAddr == {mHi, mLo}, "R2 R3 extAddr", extAddr, {mHi, mLo});
    if (isW && port == 2'd2) begin
      check(extWdata == wd, "R4 wdata", extWdata, wd);
      check(extAddr == held, "R4 addr held", extAddr, held);
    end
    if (isR && port == 2'd0) check(sysRdata == mLo, "R6 lo readback", sysRdata, mLo);
    if (isR && port == 2'd1) check(sysRdata == mHi, "R6 hi readback", sysRdata, mHi);
    @(negedge clk);
    // second cycle after the edge
    check(extWrStb == 1'b0, "R4 single wr cycle", extWrStb, 0);
    check(extRdStb == 1'b0, "R5 single rd cycle", extRdStb, 0);
    check(sysAck == (isR && port == 2'd2), "R5 R1 late ack", sysAck, isR && port == 2'd2);
    if (isR && port == 2'd2)
      check(sysRdata == devWord(held), "R5 ext read data", sysRdata, devWord(held));
    check(extAddr == {mHi, mLo}, "R1 R3 addr unchanged", extAddr, {mHi, mLo});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R7: state held in reset
    check(extAddr == '0, "R7 extAddr reset", extAddr, 0);
    check(!extWrStb && !extRdStb, "R7 strobes reset", {extWrStb, extRdStb}, 0);
    check(sysAck == 1'b0, "R7 ack reset", sysAck, 0);
    check(sysRdata == '0 && extWdata == '0, "R7 data reset", {sysRdata, extWdata}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // directed corner cases
    txn(1, 2'd0, 1, 0, 8'hA5);          // R2 low half
    txn(1, 2'd1, 1, 0, 8'h3C);          // R2 high half
    txn(1, 2'd2, 1, 0, 8'h77);          // R4 write at 3CA5
    txn(1, 2'd2, 0, 1, 8'h00);          // R5 read, R3 hold
    txn(1, 2'd2, 0, 1, 8'h00);          // R3 repeated read, no reload
    txn(1, 2'd3, 1, 0, 8'hFF);          // R1 unmapped write
    txn(1, 2'd3, 0, 1, 8'h00);          // R1 unmapped read
    txn(0, 2'd0, 1, 0, 8'h11);          // R1 chip select low
    txn(1, 2'd0, 0, 1, 8'h00);          // R6 low readback
    txn(1, 2'd1, 0, 1, 8'h00);          // R6 high readback
    txn(1, 2'd2, 1, 1, 8'h99);          // R8 write wins on data port
    txn(1, 2'd1, 1, 1, 8'hC3);          // R8 write wins on address port
    txn(1, 2'd0, 1, 0, 8'hFF);
    txn(1, 2'd1, 1, 0, 8'hFF);
    txn(1, 2'd2, 0, 1, 8'h00);          // R5 at top of space

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      bit cs, we, re;
      logic [1:0] p;
      r  = int'($urandom_range(0, 99));
      cs = (r >= 8);
      p  = 2'($urandom_range(0, 3));
      r  = int'($urandom_range(0, 9));
      we = (r < 5) || (r == 9);
      re = (r >= 5);
      txn(cs, p, we, re, 8'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule